// File: doc/BRIEF.md
# Four-Plane Raster-Op Accelerator

This block sits between a CPU bus and a small planar bitmap store. The store holds four bit planes (blue, red, green, extra) and two display pages. A single bus access can touch every enabled plane at once. An accelerated write either merges a per-plane tile colour through the CPU data, used as a pixel mask, or fills the tile colour and ignores the CPU data. An accelerated read returns a per-pixel mask of the pixels whose colour matches the tile colour. A plain path reads or writes one selected plane directly.

A register-write port loads a mode register and four 16-bit tile registers. The mode register holds a plane-disable mask and a bit that picks fill or merge for accelerated writes. Every write records which byte addresses of which page were written, through a dirty query port, and sets a sticky per-page flag. Bus accesses complete in one clock. Read results appear on a registered data output with a valid strobe.

Top module: `rop_accel`

## Requirements
- R1: After reset, the mode register, all four tile registers, every dirty bit and both page flags are zero, and `rvalid` is low.
- R2: Mode bits 0, 1, 2 and 3 disable the blue, red, green and extra planes respectively. A disabled plane is neither written by an accelerated write nor included in a compare read. Tile register index 0..3 follows the same plane order.
- R3: An accelerated write with mode bit 4 clear changes each enabled plane byte to `(old & ~data) | (data & tile_lo)`, where `tile_lo` is bits 7:0 of that plane's tile. Data bits that are 0 leave the pixel unchanged.
- R4: An accelerated write with mode bit 4 set writes `tile_lo` into each enabled plane byte, whatever the write data.
- R5: An accelerated read returns the bitwise inverse of the OR, over enabled planes, of (plane data XOR tile).
- R6: A 16-bit access uses byte address A for bits 7:0 and A+1 (wrapping within the plane) for bits 15:8. Wide accelerated writes use `tile_lo` for both bytes. Wide compare reads use the full 16-bit tile. An 8-bit read returns zero in bits 15:8.
- R7: Only the low `ADDR_W` bits of `bus_addr` select the byte. `bus_page` selects one of two page regions.
- R8: Every write sets the dirty bit of each byte it covers (both bytes when wide) at bit position `bus_page` of `dq_bits`. It also sets `page_shown[bus_page]`. Both stay set until reset, including when every plane is disabled.
- R9: With `bus_accel` low, a write stores the data bytes into plane `bus_plane` only (0 blue, 1 red, 2 green, 3 extra), and a read returns that plane's bytes.
- R10: With all four planes disabled, a compare read returns all ones (16'hFFFF wide, 16'h00FF narrow) and accelerated writes leave every plane unchanged.
- R11: A read accepted at a clock edge raises `rvalid` with its result on `rdata` at that edge. `rvalid` is low after any cycle without a read. A write is visible to the next access.
- R12: `cfg_sel` 0..3 loads tile registers, `cfg_sel` 4 loads the mode from `cfg_wdata[4:0]`, and other values are ignored. A bus access in the same cycle as a register write uses the values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_wide | input | 1 | 1 for a 16-bit access, 0 for 8-bit |
| bus_accel | input | 1 | 1 raster-op path, 0 plain plane path |
| bus_page | input | 1 | Page region select |
| bus_plane | input | 2 | Plane for plain accesses |
| bus_addr | input | BUS_AW | Byte address, truncated to ADDR_W bits |
| bus_wdata | input | 16 | Write data or pixel mask |
| rdata | output | 16 | Registered read result |
| rvalid | output | 1 | Read result valid |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0..3 tiles, 4 mode |
| cfg_wdata | input | 16 | Register write data |
| dq_addr | input | ADDR_W | Dirty query byte address |
| dq_bits | output | 2 | Dirty bits of that byte, one per page |
| page_shown | output | 2 | Sticky per-page written flags |

## Verification
A register write and a bus raster operation can land in the same cycle. The operation must then use the mode and tile values from before the write. The random stream issues a register write in about a quarter of its bus cycles, and directed cases pair a tile load with a fill and a mode change with a compare read. The bench model applies each bus operation with the old register values before it applies the register write. Any early use of the new values shows up in the compare result or in later plain read-backs of the planes.

// File: rtl/rop_pkg.sv
package rop_pkg;
  localparam int NPLANES  = 4;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int MODE_W   = 5;
  localparam int FILL_BIT = 4;
  localparam logic [2:0] CFG_MODE = 3'd4;

  typedef logic [NPLANES-1:0][BYTE_W-1:0] plane_bytes_t;
  typedef logic [NPLANES-1:0][WORD_W-1:0] tile_set_t;

  function automatic logic [BYTE_W-1:0] rmw_merge(
    input logic [BYTE_W-1:0] old_b,
    input logic [BYTE_W-1:0] mask_b,
    input logic [BYTE_W-1:0] tile_b
  );
    return (old_b & ~mask_b) | (mask_b & tile_b);
  endfunction
endpackage

// File: rtl/rop_rst_sync.sv
module rop_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      meta_q  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_s <= meta_q;
    end
  end
endmodule

// File: rtl/rop_regs.sv
module rop_regs
  import rop_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_sel,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [MODE_W-1:0]   mode_q,
  output tile_set_t           tile_q
);
  logic [MODE_W-1:0] mode_d;
  tile_set_t         tile_d;
  logic              upd_en;

  assign upd_en = cfg_we && ((cfg_sel == CFG_MODE) || (cfg_sel < 3'(NPLANES)));

  always_comb begin
    mode_d = mode_q;
    tile_d = tile_q;
    if (cfg_sel == CFG_MODE) begin
      mode_d = cfg_wdata[MODE_W-1:0];
    end else if (cfg_sel < 3'(NPLANES)) begin
      tile_d[cfg_sel[1:0]] = cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tile_q <= '0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      tile_q <= tile_d;
    end
  end
endmodule

// File: rtl/rop_plane_store.sv
module rop_plane_store
  import rop_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                page,
  input  logic [ADDR_W-1:0]   addr_lo,
  input  logic [ADDR_W-1:0]   addr_hi,
  input  logic [NPLANES-1:0]  we_lo,
  input  logic [NPLANES-1:0]  we_hi,
  input  plane_bytes_t        wd_lo,
  input  plane_bytes_t        wd_hi,
  output plane_bytes_t        rd_lo,
  output plane_bytes_t        rd_hi
);
  localparam int DEPTH = 2 << ADDR_W;

  logic [ADDR_W:0] idx_lo;
  logic [ADDR_W:0] idx_hi;

  assign idx_lo = {page, addr_lo};
  assign idx_hi = {page, addr_hi};

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    logic [BYTE_W-1:0] mem [DEPTH];

    assign rd_lo[p] = mem[idx_lo];
    assign rd_hi[p] = mem[idx_hi];

    always_ff @(posedge clk) begin
      if (we_lo[p]) begin
        mem[idx_lo] <= wd_lo[p];
      end
      if (we_hi[p]) begin
        mem[idx_hi] <= wd_hi[p];
      end
    end
  end
endmodule

// File: rtl/rop_dirty.sv
module rop_dirty #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_en,
  input  logic              mark_hi,
  input  logic              page,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic [ADDR_W-1:0] dq_addr,
  output logic [1:0]        dq_bits,
  output logic [1:0]        page_shown
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][1:0] dirty_q;
  logic [DEPTH-1:0][1:0] dirty_d;
  logic [1:0]            shown_d;

  always_comb begin
    dirty_d = dirty_q;
    shown_d = page_shown;
    dirty_d[addr_lo][page] = 1'b1;
    if (mark_hi) begin
      dirty_d[addr_hi][page] = 1'b1;
    end
    shown_d[page] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q    <= '0;
      page_shown <= '0;
    end else if (mark_en) begin
      dirty_q    <= dirty_d;
      page_shown <= shown_d;
    end
  end

  assign dq_bits = dirty_q[dq_addr];
endmodule

// File: rtl/rop_datapath.sv
module rop_datapath
  import rop_pkg::*;
(
  input  logic                wr_en,
  input  logic                wide,
  input  logic                accel,
  input  logic [1:0]          plane_sel,
  input  logic [MODE_W-1:0]   mode,
  input  tile_set_t           tiles,
  input  logic [WORD_W-1:0]   wdata,
  input  plane_bytes_t        rd_lo,
  input  plane_bytes_t        rd_hi,
  output logic [NPLANES-1:0]  we_lo,
  output logic [NPLANES-1:0]  we_hi,
  output plane_bytes_t        wd_lo,
  output plane_bytes_t        wd_hi,
  output logic [WORD_W-1:0]   rd_result
);
  logic [BYTE_W-1:0]  d_lo;
  logic [BYTE_W-1:0]  d_hi;
  logic               fill_sel;
  logic [NPLANES-1:0] plane_on;
  logic [WORD_W-1:0]  miss_acc;
  logic [WORD_W-1:0]  plain_word;
  logic [WORD_W-1:0]  raw_word;

  assign d_lo     = wdata[BYTE_W-1:0];
  assign d_hi     = wdata[WORD_W-1:BYTE_W];
  assign fill_sel = mode[FILL_BIT];

  for (genvar p = 0; p < NPLANES; p++) begin : g_lane
    logic [BYTE_W-1:0] t_lo;
    logic              direct_hit;

    assign plane_on[p] = !mode[p];
    assign t_lo        = tiles[p][BYTE_W-1:0];
    assign direct_hit  = (plane_sel == 2'(p));

    always_comb begin
      if (accel) begin
        we_lo[p] = wr_en && plane_on[p];
        we_hi[p] = wr_en && plane_on[p] && wide;
        wd_lo[p] = fill_sel ? t_lo : rmw_merge(rd_lo[p], d_lo, t_lo);
        wd_hi[p] = fill_sel ? t_lo : rmw_merge(rd_hi[p], d_hi, t_lo);
      end else begin
        we_lo[p] = wr_en && direct_hit;
        we_hi[p] = wr_en && direct_hit && wide;
        wd_lo[p] = d_lo;
        wd_hi[p] = d_hi;
      end
    end
  end

  always_comb begin
    miss_acc = '0;
    for (int p = 0; p < NPLANES; p++) begin
      if (plane_on[p]) begin
        miss_acc = miss_acc | ({rd_hi[p], rd_lo[p]} ^ tiles[p]);
      end
    end
  end

  assign plain_word = {rd_hi[plane_sel], rd_lo[plane_sel]};
  assign raw_word   = accel ? ~miss_acc : plain_word;
  assign rd_result  = wide ? raw_word : {{BYTE_W{1'b0}}, raw_word[BYTE_W-1:0]};
endmodule

// File: rtl/rop_accel.sv
module rop_accel
  import rop_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BUS_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_wide,
  input  logic              bus_accel,
  input  logic              bus_page,
  input  logic [1:0]        bus_plane,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       rdata,
  output logic              rvalid,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic [ADDR_W-1:0] dq_addr,
  output logic [1:0]        dq_bits,
  output logic [1:0]        page_shown
);
  logic               rst_n_s;
  logic [MODE_W-1:0]  mode_q;
  tile_set_t          tile_q;
  logic [ADDR_W-1:0]  addr_lo;
  logic [ADDR_W-1:0]  addr_hi;
  logic               wr_en;
  logic               rd_en;
  logic [NPLANES-1:0] we_lo;
  logic [NPLANES-1:0] we_hi;
  plane_bytes_t       wd_lo;
  plane_bytes_t       wd_hi;
  plane_bytes_t       rd_lo;
  plane_bytes_t       rd_hi;
  logic [WORD_W-1:0]  rd_result;
  logic [WORD_W-1:0]  rdata_d;
  logic               rvalid_d;

  assign addr_lo = bus_addr[ADDR_W-1:0];
  assign addr_hi = addr_lo + 1'b1;
  assign wr_en   = bus_req && bus_we;
  assign rd_en   = bus_req && !bus_we;

  rop_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  rop_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .mode_q    (mode_q),
    .tile_q    (tile_q)
  );

  rop_datapath u_dp (
    .wr_en     (wr_en),
    .wide      (bus_wide),
    .accel     (bus_accel),
    .plane_sel (bus_plane),
    .mode      (mode_q),
    .tiles     (tile_q),
    .wdata     (bus_wdata),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .we_lo     (we_lo),
    .we_hi     (we_hi),
    .wd_lo     (wd_lo),
    .wd_hi     (wd_hi),
    .rd_result (rd_result)
  );

  rop_plane_store #(.ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .page    (bus_page),
    .addr_lo (addr_lo),
    .addr_hi (addr_hi),
    .we_lo   (we_lo),
    .we_hi   (we_hi),
    .wd_lo   (wd_lo),
    .wd_hi   (wd_hi),
    .rd_lo   (rd_lo),
    .rd_hi   (rd_hi)
  );

  rop_dirty #(.ADDR_W(ADDR_W)) u_dirty (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .mark_en    (wr_en),
    .mark_hi    (bus_wide),
    .page       (bus_page),
    .addr_lo    (addr_lo),
    .addr_hi    (addr_hi),
    .dq_addr    (dq_addr),
    .dq_bits    (dq_bits),
    .page_shown (page_shown)
  );

  always_comb begin
    rvalid_d = rd_en;
    rdata_d  = rdata;
    if (rd_en) begin
      rdata_d = rd_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rvalid_d;
      rdata  <= rdata_d;
    end
  end
endmodule

// File: rtl/rop_accel_chk.sv
module rop_accel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_wide,
  input logic        bus_accel,
  input logic        bus_page,
  input logic [3:0]  mode_dis,
  input logic [15:0] rdata,
  input logic        rvalid,
  input logic [1:0]  page_shown
);
  assert_read_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> rvalid);

  assert_idle_novalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !rvalid);

  assert_shown_set0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_page) |=> page_shown[0]);

  assert_shown_set1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_page) |=> page_shown[1]);

  assert_shown_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (page_shown != 2'b00) |=> ((page_shown & $past(page_shown)) == $past(page_shown)));

  assert_cmp_all_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_accel && bus_wide && (mode_dis == 4'hF)) |=> (rdata == 16'hFFFF));

  assert_narrow_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && !bus_wide) |=> (rdata[15:8] == 8'h00));
endmodule

bind rop_accel rop_accel_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_wide   (bus_wide),
  .bus_accel  (bus_accel),
  .bus_page   (bus_page),
  .mode_dis   (mode_q[3:0]),
  .rdata      (rdata),
  .rvalid     (rvalid),
  .page_shown (page_shown)
);

// File: tb/rop_accel_tb_top.sv
`timescale 1ns/1ps
module rop_accel_tb_top;
  localparam int AW  = 6;
  localparam int BAW = 8;
  localparam int DEP = 1 << AW;

  logic           clk;
  logic           rst_n;
  logic           bus_req, bus_we, bus_wide, bus_accel, bus_page;
  logic [1:0]     bus_plane;
  logic [BAW-1:0] bus_addr;
  logic [15:0]    bus_wdata;
  logic [15:0]    rdata;
  logic           rvalid;
  logic           cfg_we;
  logic [2:0]     cfg_sel;
  logic [15:0]    cfg_wdata;
  logic [AW-1:0]  dq_addr;
  logic [1:0]     dq_bits;
  logic [1:0]     page_shown;

  int n_total = 0;
  int n_bad   = 0;

  logic [7:0]  mdl [2][4][DEP];
  logic [1:0]  dmdl [DEP];
  logic [1:0]  shown_m;
  logic [4:0]  mode_m;
  logic [15:0] tile_m [4];

  rop_accel #(.ADDR_W(AW), .BUS_AW(BAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_wide(bus_wide), .bus_accel(bus_accel), .bus_page(bus_page),
    .bus_plane(bus_plane), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rdata(rdata), .rvalid(rvalid), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dq_addr(dq_addr), .dq_bits(dq_bits),
    .page_shown(page_shown)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] f_merge(logic [7:0] o, logic [7:0] d, logic [7:0] t);
    return (o & ~d) | (d & t);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_op(bit req, bit we, bit wide, bit accel, bit pg, logic [1:0] pl,
                       logic [7:0] addr, logic [15:0] wd,
                       bit cw, logic [2:0] cs, logic [15:0] cd, string tag);
    logic [AW-1:0] a0, a1;
    logic [15:0] exp, acc;
    int pgi;
    a0  = addr[AW-1:0];
    a1  = a0 + 1'b1;
    pgi = int'(pg);
    exp = '0;
    if (req && !we) begin
      if (accel) begin
        acc = '0;
        for (int p = 0; p < 4; p++)
          if (!mode_m[p]) acc |= {mdl[pgi][p][a1], mdl[pgi][p][a0]} ^ tile_m[p];
        exp = ~acc;
      end else begin
        exp = {mdl[pgi][pl][a1], mdl[pgi][pl][a0]};
      end
      if (!wide) exp[15:8] = 8'h00;
    end
    if (req && we) begin
      for (int p = 0; p < 4; p++) begin
        if (accel && !mode_m[p]) begin
          mdl[pgi][p][a0] = mode_m[4] ? tile_m[p][7:0] : f_merge(mdl[pgi][p][a0], wd[7:0], tile_m[p][7:0]);
          if (wide)
            mdl[pgi][p][a1] = mode_m[4] ? tile_m[p][7:0] : f_merge(mdl[pgi][p][a1], wd[15:8], tile_m[p][7:0]);
        end else if (!accel && pl == 2'(p)) begin
          mdl[pgi][p][a0] = wd[7:0];
          if (wide) mdl[pgi][p][a1] = wd[15:8];
        end
      end
      dmdl[a0][pgi] = 1'b1;
      if (wide) dmdl[a1][pgi] = 1'b1;
      shown_m[pgi] = 1'b1;
    end
    if (cw) begin
      if (cs == 3'd4) mode_m = cd[4:0];
      else if (cs < 3'd4) tile_m[cs[1:0]] = cd;
    end
    @(negedge clk);
    bus_req = req; bus_we = we; bus_wide = wide; bus_accel = accel;
    bus_page = pg; bus_plane = pl; bus_addr = addr; bus_wdata = wd;
    cfg_we = cw; cfg_sel = cs; cfg_wdata = cd;
    @(posedge clk);
    #1;
    chk({tag, " R11 rvalid"}, 32'(rvalid), 32'(req && !we));
    if (req && !we) chk(tag, 32'(rdata), 32'(exp));
    bus_req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic rd(bit wide, bit accel, bit pg, logic [1:0] pl, logic [7:0] a, string tag);
    do_op(1, 0, wide, accel, pg, pl, a, 16'h0, 0, 3'd0, 16'h0, tag);
  endtask

  task automatic wr(bit wide, bit accel, bit pg, logic [1:0] pl, logic [7:0] a, logic [15:0] d, string tag);
    do_op(1, 1, wide, accel, pg, pl, a, d, 0, 3'd0, 16'h0, tag);
  endtask

  task automatic cfg(logic [2:0] s, logic [15:0] d);
    do_op(0, 0, 0, 0, 0, 2'd0, 8'h0, 16'h0, 1, s, d, "R12 cfg");
  endtask

  task automatic sweep_dirty(string tag);
    for (int a = 0; a < DEP; a++) begin
      @(negedge clk);
      dq_addr = AW'(a);
      #1;
      chk(tag, 32'(dq_bits), 32'(dmdl[a]));
    end
    chk({tag, " shown"}, 32'(page_shown), 32'(shown_m));
  endtask

  task automatic readback_all(string tag);
    for (int pg = 0; pg < 2; pg++)
      for (int p = 0; p < 4; p++)
        for (int a = 0; a < DEP; a += 2)
          rd(1, 0, pg[0], 2'(p), 8'(a), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_bad++;
    $display("FAIL R11 watchdog act=%0d exp=0", 200000);
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    bus_req = 0; bus_we = 0; bus_wide = 0; bus_accel = 0; bus_page = 0;
    bus_plane = 0; bus_addr = 0; bus_wdata = 0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; dq_addr = 0;
    for (int a = 0; a < DEP; a++) dmdl[a] = 2'b00;
    shown_m = 2'b00; mode_m = 5'h0;
    for (int p = 0; p < 4; p++) tile_m[p] = 16'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rvalid", 32'(rvalid), 32'd0);
    sweep_dirty("R1 dirty");

    // R8 dirty marking before memory init, wrap on page 1 (R6)
    wr(1, 0, 1, 2'd2, 8'h3F, 16'hABCD, "R8 wr");
    wr(0, 0, 0, 2'd0, 8'h05, 16'h0011, "R8 wr");
    sweep_dirty("R8 dirty");

    // Memory init through the plain path (R9)
    for (int pg = 0; pg < 2; pg++)
      for (int p = 0; p < 4; p++)
        for (int a = 0; a < DEP; a += 2)
          wr(1, 0, pg[0], 2'(p), 8'(a), 16'($urandom), "R9 init");
    readback_all("R9 plain readback");

    // R1 registers zero: compare against zero tiles, all planes on
    rd(1, 1, 0, 2'd0, 8'h06, "R1 R5 cmp zero tiles");
    rd(0, 1, 1, 2'd0, 8'h21, "R1 R5 cmp zero tiles");

    // R3 merge, R2 plane order
    cfg(3'd0, 16'h12F0); cfg(3'd1, 16'h340F); cfg(3'd2, 16'h56AA); cfg(3'd3, 16'h7855);
    cfg(3'd4, 16'h0004);
    wr(0, 1, 0, 2'd0, 8'h10, 16'h00C3, "R3 R2 merge");
    for (int p = 0; p < 4; p++) rd(0, 0, 0, 2'(p), 8'h10, "R3 R2 readback");
    rd(1, 1, 0, 2'd0, 8'h10, "R5 R2 cmp");

    // R4 fill ignores data, wide wrap (R6), truncation (R7)
    cfg(3'd4, 16'h0010);
    wr(1, 1, 1, 2'd0, 8'hFF, 16'h1234, "R4 R6 R7 fill");
    for (int p = 0; p < 4; p++) begin
      rd(1, 0, 1, 2'(p), 8'h3F, "R4 R6 readback");
      rd(0, 0, 1, 2'(p), 8'h00, "R4 R6 wrap readback");
    end
    rd(1, 0, 0, 2'd1, 8'hC5, "R7 alias");

    // R10 all planes off
    cfg(3'd4, 16'h000F);
    rd(1, 1, 0, 2'd0, 8'h08, "R10 cmp wide");
    rd(0, 1, 1, 2'd0, 8'h09, "R10 cmp narrow");
    wr(1, 1, 0, 2'd0, 8'h08, 16'hFFFF, "R10 merge");
    cfg(3'd4, 16'h001F);
    wr(1, 1, 1, 2'd0, 8'h09, 16'hFFFF, "R10 fill");
    for (int p = 0; p < 4; p++) begin
      rd(1, 0, 0, 2'(p), 8'h08, "R10 unchanged");
      rd(1, 0, 1, 2'(p), 8'h09, "R10 unchanged");
    end

    // R12 same-cycle config and op, ignored selects
    cfg(3'd4, 16'h0010);
    do_op(1, 1, 0, 1, 0, 2'd0, 8'h20, 16'h5555, 1, 3'd0, 16'h00EE, "R12 fill");
    rd(0, 0, 0, 2'd0, 8'h20, "R12 old tile used");
    do_op(1, 0, 1, 1, 0, 2'd0, 8'h20, 16'h0, 1, 3'd4, 16'h000E, "R12 cmp old mode");
    cfg(3'd6, 16'h001F);
    rd(1, 1, 0, 2'd0, 8'h20, "R12 ignored sel");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      bit we, wide, accel, pg, cw;
      logic [2:0] cs;
      logic [15:0] cd;
      we = $urandom_range(0, 1) == 1;
      wide = $urandom_range(0, 1) == 1;
      accel = $urandom_range(0, 2) != 0;
      pg = $urandom_range(0, 1) == 1;
      cw = $urandom_range(0, 3) == 0;
      cs = 3'($urandom_range(0, 5));
      cd = 16'($urandom);
      if (cs == 3'd4 && $urandom_range(0, 3) == 0) cd[3:0] = 4'hF;
      do_op(1, we, wide, accel, pg, 2'($urandom_range(0, 3)), 8'($urandom), 16'($urandom),
            cw, cs, cd, accel ? (we ? "R3 R4 rand" : "R5 R6 rand cmp") : "R9 rand");
    end
    readback_all("R3 R4 R9 final readback");
    sweep_dirty("R8 final dirty");

    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule